// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This integer execution unit computes a base plus a scaled index, the core step of array indexing and address generation. It takes one 32-bit instruction word together with the two source operand values (a base and an index), decodes which of three variants is requested, extends the index as that variant demands, multiplies it by 2, 4, 8 or 16 through a left shift, and adds the base. The 64-bit sum, the destination register number, a write enable and, when requested, a three-way sign report on the result leave the unit one cycle after the input is taken.

Operands enter on a valid/ready handshake. The result sits in an output register that is held while the consumer is not ready; during that time the unit refuses new input. An instruction word that matches none of the configured opcodes still produces an output beat, marked illegal, with no register write.

Top module: `sa_unit`

## Requirements
- R1: The instruction word is numbered with bit 0 as its most significant bit (insn_i[31]): primary opcode in bits 0-5, destination register in 6-10, base register in 11-15, index register in 16-20, shift field in 21-22, extended opcode in 23-30, record bit in 31. rt_o returns bits 6-10 of the accepted word.
- R2: The shift applied to the index is the 2-bit shift field plus one, so field values 0, 1, 2, 3 scale by 2, 4, 8, 16.
- R3: With primary opcode PO_VAL (default 22) and extended opcode XO_FULL (default 9), result_o is base + (index << shift) over the full 64-bit unsigned index, keeping only the low 64 bits; bits shifted above bit 63 and the carry out are dropped.
- R4: With extended opcode XO_SWORD (default 10), only index bits 31:0 are used, sign-extended to 64 bits, before the shift and add.
- R5: With extended opcode XO_UWORD (default 11), only index bits 31:0 are used, zero-extended to 64 bits, before the shift and add.
- R6: A word whose primary opcode is not PO_VAL or whose extended opcode matches none of the three values gives an output beat with illegal_o=1, wr_en_o=0, cr_valid_o=0 and result_o=0; legal operations give illegal_o=0 and wr_en_o=1.
- R7: For a legal operation with the record bit set, cr_valid_o=1 and cr_o is 3'b100 if the result is negative as a signed 64-bit value, 3'b010 if positive, 3'b001 if zero; otherwise cr_valid_o=0 and cr_o=0.
- R8: out_valid_o rises in the cycle after an input is accepted (in_valid_i and in_ready_o high at a rising edge), and one output beat is produced per accepted input.
- R9: While out_valid_o is high and out_ready_i low, all outputs hold their values and in_ready_o is low.
- R10: Asserting rst_ni low clears out_valid_o, wr_en_o, illegal_o, cr_valid_o and cr_o at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input operation offered |
| in_ready_o | output | 1 | Unit can take an operation this cycle |
| insn_i | input | 32 | Instruction word |
| base_i | input | 64 | Base operand value |
| index_i | input | 64 | Index operand value |
| out_valid_o | output | 1 | Output beat present |
| out_ready_i | input | 1 | Consumer takes the output beat |
| result_o | output | 64 | Scaled sum |
| rt_o | output | 5 | Destination register number |
| wr_en_o | output | 1 | Destination should be written |
| illegal_o | output | 1 | Instruction not recognised |
| cr_valid_o | output | 1 | cr_o carries a sign report |
| cr_o | output | 3 | Negative, positive, zero flags |

## Verification
The two functions that meet in one cycle are the draining of a held output and the acceptance of the next operation: when out_ready_i returns high, the output register must both release its beat and load a new one at the same edge. The bench provokes this with back-to-back operations under randomly toggled out_ready_i, and a queue-based model checks on every clock that no beat is lost, duplicated or altered while held, and that in_ready_o is low exactly when a beat is stalled.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned ILEN  = 32;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned WLEN  = 32;
  localparam int unsigned SHW   = 2;
  localparam int unsigned REGW  = 5;
  localparam int unsigned POW   = 6;
  localparam int unsigned XOW   = 8;
  // shift field plus one needs one more bit
  localparam int unsigned SHAMTW = $clog2((1 << SHW) + 1);

  // LSB-first positions of the MSB-first numbered fields
  localparam int unsigned PO_LSB = ILEN - POW;
  localparam int unsigned RT_LSB = PO_LSB - REGW;
  localparam int unsigned RA_LSB = RT_LSB - REGW;
  localparam int unsigned RB_LSB = RA_LSB - REGW;
  localparam int unsigned SH_LSB = RB_LSB - SHW;
  localparam int unsigned XO_LSB = SH_LSB - XOW;

  typedef enum logic [1:0] {
    OP_FULL  = 2'd0,
    OP_SWORD = 2'd1,
    OP_UWORD = 2'd2,
    OP_NONE  = 2'd3
  } sa_op_e;

  typedef struct packed {
    sa_op_e            op;
    logic [REGW-1:0]   rt;
    logic [REGW-1:0]   ra;
    logic [REGW-1:0]   rb;
    logic [SHW-1:0]    sh;
    logic              rc;
  } sa_dec_t;
endpackage

// File: rtl/sa_decode.sv
module sa_decode
  import sa_pkg::*;
#(
  parameter logic [POW-1:0] PO_VAL   = 6'd22,
  parameter logic [XOW-1:0] XO_FULL  = 8'd9,
  parameter logic [XOW-1:0] XO_SWORD = 8'd10,
  parameter logic [XOW-1:0] XO_UWORD = 8'd11
) (
  input  logic [ILEN-1:0] insn_i,
  output sa_dec_t         dec_o
);
  logic [POW-1:0] po;
  logic [XOW-1:0] xo;

  assign po = insn_i[PO_LSB +: POW];
  assign xo = insn_i[XO_LSB +: XOW];

  always_comb begin
    dec_o.rt = insn_i[RT_LSB +: REGW];
    dec_o.ra = insn_i[RA_LSB +: REGW];
    dec_o.rb = insn_i[RB_LSB +: REGW];
    dec_o.sh = insn_i[SH_LSB +: SHW];
    dec_o.rc = insn_i[0];
    dec_o.op = OP_NONE;
    if (po == PO_VAL) begin
      if (xo == XO_FULL)       dec_o.op = OP_FULL;
      else if (xo == XO_SWORD) dec_o.op = OP_SWORD;
      else if (xo == XO_UWORD) dec_o.op = OP_UWORD;
    end
  end
endmodule

// File: rtl/sa_scale.sv
module sa_scale
  import sa_pkg::*;
(
  input  sa_op_e          op_i,
  input  logic [SHW-1:0]  sh_i,
  input  logic [XLEN-1:0] index_i,
  output logic [XLEN-1:0] scaled_o
);
  logic [XLEN-1:0]   ext;
  logic [SHAMTW-1:0] shamt;
  logic [XLEN-1:0]   stage [SHAMTW+1];

  assign shamt = SHAMTW'(sh_i) + SHAMTW'(1);

  always_comb begin
    unique case (op_i)
      OP_SWORD: ext = {{(XLEN-WLEN){index_i[WLEN-1]}}, index_i[WLEN-1:0]};
      OP_UWORD: ext = {{(XLEN-WLEN){1'b0}}, index_i[WLEN-1:0]};
      default:  ext = index_i;
    endcase
  end

  assign stage[0] = ext;

  // log-depth shifter, one mux row per shift bit
  for (genvar k = 0; k < SHAMTW; k++) begin : g_shift
    assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign scaled_o = stage[SHAMTW];
endmodule

// File: rtl/sa_cond.sv
module sa_cond
  import sa_pkg::*;
(
  input  logic [XLEN-1:0] value_i,
  output logic [2:0]      cr_o
);
  logic neg, zero;

  assign neg  = value_i[XLEN-1];
  assign zero = (value_i == '0);
  assign cr_o = {neg, ~neg & ~zero, zero};
endmodule

// File: rtl/sa_unit.sv
module sa_unit
  import sa_pkg::*;
#(
  parameter logic [POW-1:0] PO_VAL   = 6'd22,
  parameter logic [XOW-1:0] XO_FULL  = 8'd9,
  parameter logic [XOW-1:0] XO_SWORD = 8'd10,
  parameter logic [XOW-1:0] XO_UWORD = 8'd11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [ILEN-1:0] insn_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] result_o,
  output logic [REGW-1:0] rt_o,
  output logic            wr_en_o,
  output logic            illegal_o,
  output logic            cr_valid_o,
  output logic [2:0]      cr_o
);
  sa_dec_t         dec;
  logic [XLEN-1:0] scaled, sum;
  logic [2:0]      cr_n;
  logic            accept, legal, rec;
  logic [2*REGW-1:0] unused_srcs;

  logic            valid_q, wr_q, ill_q, crv_q;
  logic [2:0]      cr_q;
  logic [XLEN-1:0] res_q;
  logic [REGW-1:0] rt_q;

  sa_decode #(
    .PO_VAL  (PO_VAL),
    .XO_FULL (XO_FULL),
    .XO_SWORD(XO_SWORD),
    .XO_UWORD(XO_UWORD)
  ) u_dec (
    .insn_i(insn_i),
    .dec_o (dec)
  );

  sa_scale u_scale (
    .op_i    (dec.op),
    .sh_i    (dec.sh),
    .index_i (index_i),
    .scaled_o(scaled)
  );

  // carry out of the top bit is dropped
  assign sum = base_i + scaled;

  sa_cond u_cond (
    .value_i(sum),
    .cr_o   (cr_n)
  );

  // source register numbers are read by the register file, not here
  assign unused_srcs = {dec.ra, dec.rb};

  assign legal      = (dec.op != OP_NONE);
  assign rec        = legal & dec.rc;
  assign in_ready_o = ~valid_q | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      ill_q   <= 1'b0;
      crv_q   <= 1'b0;
      cr_q    <= '0;
      res_q   <= '0;
      rt_q    <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      wr_q    <= legal;
      ill_q   <= ~legal;
      crv_q   <= rec;
      cr_q    <= rec ? cr_n : 3'b000;
      res_q   <= legal ? sum : '0;
      rt_q    <= dec.rt;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      ill_q   <= 1'b0;
      crv_q   <= 1'b0;
      cr_q    <= '0;
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;
  assign rt_o        = rt_q;
  assign wr_en_o     = wr_q;
  assign illegal_o   = ill_q;
  assign cr_valid_o  = crv_q;
  assign cr_o        = cr_q;

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) &&
    $stable(rt_o) && $stable(cr_o) && $stable(illegal_o) && $stable(wr_en_o));

  a_r9_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r6_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o && !cr_valid_o && result_o == '0);

  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> $countones(cr_o) == 1);

  a_r7_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> cr_o[2] == result_o[XLEN-1] && cr_o[0] == (result_o == '0));

  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && legal |->
      (scaled & ((XLEN'(1) << (32'(dec.sh) + 1)) - XLEN'(1))) == '0);

  a_r8_beat_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !wr_en_o && !illegal_o && !cr_valid_o);
endmodule

// File: tb/sa_unit_test.sv
module sa_unit_test;
  localparam logic [5:0] PO  = 6'd22;
  localparam logic [7:0] XF  = 8'd9;
  localparam logic [7:0] XS  = 8'd10;
  localparam logic [7:0] XU  = 8'd11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [63:0] base = '0, idx = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] result;
  logic [4:0]  rt;
  logic        wr_en, illegal, cr_valid;
  logic [2:0]  cr;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [63:0] res;
    logic [4:0]  rt;
    logic        wr;
    logic        ill;
    logic        crv;
    logic [2:0]  cr;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  sa_unit uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .insn_i(insn), .base_i(base), .index_i(idx),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .result_o(result), .rt_o(rt), .wr_en_o(wr_en),
    .illegal_o(illegal), .cr_valid_o(cr_valid), .cr_o(cr)
  );

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] d, logic [1:0] sh,
                                     logic [7:0] xo, logic rc);
    return {po, d, 5'd3, 5'd4, sh, xo, rc};
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [63:0] b, logic [63:0] x,
                                 logic [7:0] tag);
    exp_t e;
    logic [63:0] n;
    logic        ok;
    int          s;
    ok = 1'b1;
    n  = x;
    if (w[31:26] != PO) ok = 1'b0;
    else if (w[8:1] == XF) n = x;
    else if (w[8:1] == XS) n = {{32{x[31]}}, x[31:0]};
    else if (w[8:1] == XU) n = {32'd0, x[31:0]};
    else ok = 1'b0;
    s = int'(w[10:9]) + 1;
    e.rt  = w[25:21];
    e.wr  = ok;
    e.ill = !ok;
    e.res = ok ? b + (n << s) : 64'd0;
    e.crv = ok && w[0];
    if (!e.crv)                 e.cr = 3'b000;
    else if ($signed(e.res) < 0) e.cr = 3'b100;
    else if (e.res == 0)        e.cr = 3'b001;
    else                        e.cr = 3'b010;
    e.tag = tag;
    return e;
  endfunction

  task automatic check(logic ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare outputs against model; sampled at negedge
  task automatic compare();
    string t;
    if (out_valid) begin
      check(q.size() != 0, "R8", 64'(out_valid), 64'(q.size() != 0));
      if (q.size() != 0) begin
        t = $sformatf("R%0d", q[0].tag);
        check(result == q[0].res, t, result, q[0].res);
        check(rt == q[0].rt, "R1", 64'(rt), 64'(q[0].rt));
        check(wr_en == q[0].wr && illegal == q[0].ill, "R6",
              64'({wr_en, illegal}), 64'({q[0].wr, q[0].ill}));
        check(cr_valid == q[0].crv && cr == q[0].cr, "R7",
              64'({cr_valid, cr}), 64'({q[0].crv, q[0].cr}));
      end
    end else begin
      check(q.size() == 0, "R8", 64'(out_valid), 64'(q.size() != 0));
    end
  endtask

  task automatic step(logic v, logic [31:0] w, logic [63:0] b, logic [63:0] x,
                      logic ordy, logic [7:0] tag);
    @(negedge clk);
    compare();
    in_valid  = v;
    insn      = w;
    base      = b;
    idx       = x;
    out_ready = ordy;
    #1;
    if (out_valid && !out_ready)
      check(!in_ready, "R9", 64'(in_ready), 64'd0);
    if (out_valid && out_ready) void'(q.pop_front());
    if (in_valid && in_ready) q.push_back(model(w, b, x, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b1, 8'd8);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state
    #2;
    check(!out_valid && !wr_en && !illegal && !cr_valid && cr == 0, "R10",
          64'({out_valid, wr_en, illegal, cr_valid, cr}), 64'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R2: each shift field value
    for (int s = 0; s < 4; s++)
      step(1'b1, mk(PO, 5'(s + 1), 2'(s), XF, 1'b0), 64'h1000, 64'h3, 1'b1, 8'd2);
    idle(2);

    // R3: full width, wrap of shifted bits and carry
    step(1'b1, mk(PO, 5'd7, 2'd3, XF, 1'b0), 64'hFFFF_FFFF_FFFF_FFF0, 64'hF000_0000_0000_0001, 1'b1, 8'd3);
    step(1'b1, mk(PO, 5'd8, 2'd0, XF, 1'b0), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 8'd3);
    step(1'b1, mk(PO, 5'd9, 2'd1, XF, 1'b0), 64'd5, 64'h0000_0001_0000_0000, 1'b1, 8'd3);
    // R4: signed word, negative and positive, upper bits ignored
    step(1'b1, mk(PO, 5'd10, 2'd2, XS, 1'b0), 64'h1_0000, 64'hDEAD_BEEF_FFFF_FFFF, 1'b1, 8'd4);
    step(1'b1, mk(PO, 5'd11, 2'd0, XS, 1'b0), 64'h100, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1, 8'd4);
    // R5: zero-extended word
    step(1'b1, mk(PO, 5'd12, 2'd2, XU, 1'b0), 64'h1_0000, 64'hDEAD_BEEF_FFFF_FFFF, 1'b1, 8'd5);
    step(1'b1, mk(PO, 5'd13, 2'd3, XU, 1'b0), 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b1, 8'd5);
    idle(2);

    // R6: wrong extended opcode, wrong primary opcode, record bit on illegal
    step(1'b1, mk(PO, 5'd14, 2'd0, 8'd12, 1'b1), 64'd1, 64'd1, 1'b1, 8'd6);
    step(1'b1, mk(6'd23, 5'd15, 2'd0, XF, 1'b0), 64'd1, 64'd1, 1'b1, 8'd6);
    step(1'b1, mk(PO, 5'd16, 2'd1, 8'd0, 1'b0), 64'd9, 64'd9, 1'b1, 8'd6);
    idle(2);

    // R7: negative, positive, zero with record bit
    step(1'b1, mk(PO, 5'd17, 2'd0, XS, 1'b1), 64'd0, 64'hFFFF_FFFF, 1'b1, 8'd7);
    step(1'b1, mk(PO, 5'd18, 2'd1, XF, 1'b1), 64'd3, 64'd2, 1'b1, 8'd7);
    step(1'b1, mk(PO, 5'd19, 2'd0, XS, 1'b1), 64'd2, 64'hFFFF_FFFF, 1'b1, 8'd7);
    step(1'b1, mk(PO, 5'd20, 2'd0, XU, 1'b0), 64'd2, 64'hFFFF_FFFF, 1'b1, 8'd7);
    idle(2);

    // R9: long stall, then release together with a new input
    step(1'b1, mk(PO, 5'd21, 2'd2, XF, 1'b1), 64'd100, 64'd7, 1'b0, 8'd9);
    step(1'b1, mk(PO, 5'd22, 2'd3, XU, 1'b0), 64'd1, 64'd1, 1'b0, 8'd9);
    step(1'b1, mk(PO, 5'd22, 2'd3, XU, 1'b0), 64'd1, 64'd1, 1'b0, 8'd9);
    step(1'b1, mk(PO, 5'd22, 2'd3, XU, 1'b0), 64'd1, 64'd1, 1'b1, 8'd9);
    idle(3);

    // R8: random traffic with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] xo;
      logic [7:0] tg;
      int         pick;
      pick = int'($urandom_range(0, 3));
      xo = (pick == 0) ? XF : (pick == 1) ? XS : (pick == 2) ? XU : 8'($urandom);
      tg = (xo == XF) ? 8'd3 : (xo == XS) ? 8'd4 : (xo == XU) ? 8'd5 : 8'd6;
      step(1'($urandom), mk(($urandom_range(0, 9) == 0) ? 6'($urandom) : PO,
                            5'($urandom), 2'($urandom), xo, 1'($urandom)),
           {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(0, 3) != 0), tg);
    end
    idle(3);

    // R10: reset while a beat is stalled
    step(1'b1, mk(PO, 5'd5, 2'd0, XF, 1'b1), 64'd1, 64'd1, 1'b0, 8'd3);
    @(negedge clk);
    compare();
    rst_ni = 1'b0;
    q.delete();
    #1;
    check(!out_valid && !wr_en && !illegal && !cr_valid && cr == 0, "R10",
          64'({out_valid, wr_en, illegal, cr_valid, cr}), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    step(1'b1, mk(PO, 5'd6, 2'd1, XS, 1'b1), 64'd0, 64'd0, 1'b1, 8'd10);
    idle(3);

    summary();
    $finish;
  end
endmodule